// File: doc/BRIEF.md
# Bit-masked PHY control register bank

This block holds the control settings for a storage-interface PHY, plus one read-only word that reports live PHY status. It sits on a simple register bus with a byte address, a 32-bit write word, a write strobe, a read strobe and a registered read word. Software can flip single control bits without reading first. To do that, a write word carries its own per-bit enable: the upper 16 bits say which of the lower 16 bits take the new value.

There are seven control words, each 16 bits wide. All of them drive the PHY through a flat output bus. Two bits of the last control word, the power-up bit and the delay-line enable, are also brought out on their own pins. The status word returns the calibration-done and delay-line-ready inputs at the moment it is read. Every control bit resets to zero, so the PHY comes out of reset powered down with its delay line off.

Top module: `phyctl_regbank`

## Requirements
- R1: While `rst` is high at a clock edge, every control bit, `phy_pwr_on`, `dll_en` and `rdata` become 0.
- R2: A write to a control word sets bit x (0..15) to `wdata[x]` only when `wdata[x+16]` is 1. Every other bit keeps its value.
- R3: The control words sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18, in that order, one per 4 bytes. A write to one of them leaves the others unchanged.
- R4: A read of a control word returns its 16 bits in `rdata[15:0]` and zero in `rdata[31:16]`.
- R5: A read of offset 0x20 returns `cal_done` in bit 6 and `dll_ready` in bit 5, both sampled at the read edge, with all other bits zero.
- R6: Writes to 0x20, to 0x1C, to any offset above 0x20, or to any offset whose low two bits are not 00 change no control bit.
- R7: Reads of 0x1C, of any offset above 0x20, and of misaligned offsets return zero.
- R8: `rdata` loads at the clock edge where `rd_en` is high and holds its value until the next read. When a write and a read hit the same word in the same cycle, the read returns the value from before the write.
- R9: `phy_pwr_on` is bit 0 and `dll_en` is bit 1 of the word at 0x18. Control word k appears on `ctrl_bits[16k+15:16k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write word: upper half is per-bit enable, lower half is the new value |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read word, valid the cycle after `rd_en` |
| ctrl_bits | output | 112 | All control words, word k on bits [16k+15:16k] |
| phy_pwr_on | output | 1 | PHY power-up control, 1 = powered on |
| dll_en | output | 1 | Delay-line enable control, 1 = enabled |
| cal_done | input | 1 | PHY calibration finished |
| dll_ready | input | 1 | PHY delay line locked |

## Verification
The bench exercises the mask with partial enables, an all-zero enable and a clear of one bit beside a set neighbour. A design that used the plain data, or shifted the mask by the wrong amount, would corrupt the neighbouring bits. It writes to 0x1C, to the status word, above the status word and to misaligned offsets, then confirms the stored words are intact. A decoder that drops the low address bits or wraps the index would overwrite a real control word. A same-cycle read and write catches read data taken after the update, and idle cycles catch read data that is not held. The status bit positions are checked for each input pattern, so swapped status bits would be caught.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

    localparam int DATA_W      = 32;
    localparam int HALF_W      = DATA_W / 2;
    localparam int ADDR_W      = 8;
    localparam int NUM_CTRL    = 7;
    localparam int IDX_W       = $clog2(NUM_CTRL);
    localparam int WORD_AW     = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] STAT_OFFSET = 8'h20;

    // status bit positions
    localparam int CAL_DONE_BIT = 6;
    localparam int DLL_RDY_BIT  = 5;

    // control word that carries the power / delay-line bits
    localparam int PWR_WORD    = 6;
    localparam int PWR_BIT     = 0;
    localparam int DLL_EN_BIT  = 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } sel_t;

    // per-bit merge: upper half of the write word enables the lower half
    function automatic logic [HALF_W-1:0] merge_masked(
        input logic [HALF_W-1:0] cur,
        input logic [DATA_W-1:0] wr
    );
        logic [HALF_W-1:0] en;
        logic [HALF_W-1:0] val;
        en  = wr[DATA_W-1:HALF_W];
        val = wr[HALF_W-1:0];
        return (cur & ~en) | (val & en);
    endfunction

endpackage

// File: rtl/phyctl_decode.sv
module phyctl_decode
    import phyctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    localparam logic [WORD_AW-1:0] CTRL_LIMIT = WORD_AW'(NUM_CTRL);

    logic [WORD_AW-1:0] word;
    logic               aligned;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        sel.kind = SEL_NONE;
        sel.idx  = '0;
        if (aligned && (word < CTRL_LIMIT)) begin
            sel.kind = SEL_CTRL;
            sel.idx  = word[IDX_W-1:0];
        end else if (addr == STAT_OFFSET) begin
            sel.kind = SEL_STAT;
        end
    end
endmodule

// File: rtl/phyctl_mreg.sv
module phyctl_mreg
    import phyctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [HALF_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= merge_masked(q, wdata);
        end
    end
endmodule

// File: rtl/phyctl_rdmux.sv
module phyctl_rdmux
    import phyctl_pkg::*;
(
    input  sel_t                       sel,
    input  logic [NUM_CTRL*HALF_W-1:0] ctrl_flat,
    input  logic                       cal_done,
    input  logic                       dll_ready,
    output logic [DATA_W-1:0]          rd_next
);
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        stat_word               = '0;
        stat_word[CAL_DONE_BIT] = cal_done;
        stat_word[DLL_RDY_BIT]  = dll_ready;
    end

    always_comb begin
        unique case (sel.kind)
            SEL_CTRL: rd_next = {{HALF_W{1'b0}}, ctrl_flat[sel.idx*HALF_W +: HALF_W]};
            SEL_STAT: rd_next = stat_word;
            default:  rd_next = '0;
        endcase
    end
endmodule

// File: rtl/phyctl_regbank.sv
module phyctl_regbank
    import phyctl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       wr_en,
    input  logic                       rd_en,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_CTRL*HALF_W-1:0] ctrl_bits,
    output logic                       phy_pwr_on,
    output logic                       dll_en,
    input  logic                       cal_done,
    input  logic                       dll_ready
);
    sel_t              sel;
    logic [DATA_W-1:0] rd_next;

    phyctl_decode u_decode (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_word
        logic we_k;
        assign we_k = wr_en && (sel.kind == SEL_CTRL) && (sel.idx == IDX_W'(k));

        phyctl_mreg u_reg (
            .clk   (clk),
            .rst   (rst),
            .we    (we_k),
            .wdata (wdata),
            .q     (ctrl_bits[k*HALF_W +: HALF_W])
        );
    end

    assign phy_pwr_on = ctrl_bits[PWR_WORD*HALF_W + PWR_BIT];
    assign dll_en     = ctrl_bits[PWR_WORD*HALF_W + DLL_EN_BIT];

    phyctl_rdmux u_rdmux (
        .sel       (sel),
        .ctrl_flat (ctrl_bits),
        .cal_done  (cal_done),
        .dll_ready (dll_ready),
        .rd_next   (rd_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end
endmodule

// File: rtl/phyctl_regbank_chk.sv
module phyctl_regbank_chk
    import phyctl_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [ADDR_W-1:0]          addr,
    input logic [DATA_W-1:0]          wdata,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [DATA_W-1:0]          rdata,
    input logic [NUM_CTRL*HALF_W-1:0] ctrl_bits,
    input logic                       phy_pwr_on,
    input logic                       dll_en,
    input logic                       cal_done,
    input logic                       dll_ready
);
    localparam logic [ADDR_W-1:0] PWR_ADDR = ADDR_W'(PWR_WORD * 4);
    localparam logic [ADDR_W-1:0] HOLE     = ADDR_W'(NUM_CTRL * 4);

    // R1: leaving reset, all control state is cleared
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_bits == '0 && rdata == '0 && !phy_pwr_on && !dll_en));

    // R2: no write strobe, no change
    a_r2_no_write_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_bits));

    // R2: power bit untouched when its enable bit is clear
    a_r2_masked_pwr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == PWR_ADDR && !wdata[HALF_W + PWR_BIT]) |=> $stable(phy_pwr_on));

    // R4: control reads return zero upper half
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr < HOLE) |=> (rdata[DATA_W-1:HALF_W] == '0));

    // R5: status bits reflect the inputs at the read edge
    a_r5_status_bits: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == STAT_OFFSET) |=>
            (rdata[CAL_DONE_BIT] == $past(cal_done) && rdata[DLL_RDY_BIT] == $past(dll_ready)));

    // R6: writes outside the control words change nothing
    a_r6_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr >= HOLE || addr[1:0] != 2'b00)) |=> $stable(ctrl_bits));

    // R7: reads above the status word return zero
    a_r7_unmapped_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr > STAT_OFFSET) |=> (rdata == '0));

    // R8: read data holds between reads
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

bind phyctl_regbank phyctl_regbank_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wdata      (wdata),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .ctrl_bits  (ctrl_bits),
    .phy_pwr_on (phy_pwr_on),
    .dll_en     (dll_en),
    .cal_done   (cal_done),
    .dll_ready  (dll_ready)
);

// File: tb/test_phyctl_regbank.sv
module test_phyctl_regbank;
    import phyctl_pkg::*;

    localparam int CLK_P = 10;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [ADDR_W-1:0]          addr = '0;
    logic [DATA_W-1:0]          wdata = '0;
    logic                       wr_en = 1'b0;
    logic                       rd_en = 1'b0;
    logic [DATA_W-1:0]          rdata;
    logic [NUM_CTRL*HALF_W-1:0] ctrl_bits;
    logic                       phy_pwr_on;
    logic                       dll_en;
    logic                       cal_done = 1'b0;
    logic                       dll_ready = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    phyctl_regbank i_phyctl_regbank (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .wdata      (wdata),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .rdata      (rdata),
        .ctrl_bits  (ctrl_bits),
        .phy_pwr_on (phy_pwr_on),
        .dll_en     (dll_en),
        .cal_done   (cal_done),
        .dll_ready  (dll_ready)
    );

    typedef struct packed {
        logic        rd;    // 1 = read and compare, 0 = write
        logic [7:0]  a;
        logic [31:0] d;     // write word or expected read word
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'h0000_0000},  // R1 reset value
        '{1'b0, 8'h00, 32'hFFFF_A5A5},
        '{1'b1, 8'h00, 32'h0000_A5A5},  // R2 R4
        '{1'b0, 8'h00, 32'h00F0_0000},
        '{1'b1, 8'h00, 32'h0000_A505},  // R2 partial clear
        '{1'b0, 8'h00, 32'h0000_FFFF},
        '{1'b1, 8'h00, 32'h0000_A505},  // R2 empty enable
        '{1'b0, 8'h04, 32'hFFFF_1234},
        '{1'b1, 8'h04, 32'h0000_1234},  // R3
        '{1'b1, 8'h00, 32'h0000_A505},  // R3 neighbour intact
        '{1'b0, 8'h14, 32'hFFFF_BEEF},
        '{1'b1, 8'h14, 32'h0000_BEEF},  // R3
        '{1'b0, 8'h18, 32'h0003_0003},
        '{1'b1, 8'h18, 32'h0000_0003},  // R3 R9
        '{1'b0, 8'h1C, 32'hFFFF_FFFF},
        '{1'b1, 8'h1C, 32'h0000_0000},  // R6 R7
        '{1'b0, 8'h20, 32'hFFFF_FFFF},
        '{1'b0, 8'h01, 32'hFFFF_FFFF},
        '{1'b1, 8'h00, 32'h0000_A505},  // R6
        '{1'b1, 8'h24, 32'h0000_0000},  // R7
        '{1'b1, 8'h08, 32'h0000_0000},  // R3
        '{1'b1, 8'h10, 32'h0000_0000},  // R3
        '{1'b1, 8'h02, 32'h0000_0000}   // R7 misaligned
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [NUM_CTRL*HALF_W-1:0] snap;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 ctrl_bits after reset", 128'(ctrl_bits), 128'(0));
        check("R1 phy_pwr_on after reset", 128'(phy_pwr_on), 128'(0));
        check("R1 dll_en after reset", 128'(dll_en), 128'(0));
        check("R1 rdata after reset", 128'(rdata), 128'(0));

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                do_read(VECS[i].a, rv);
                check($sformatf("table row %0d read R2/R3/R4/R6/R7", i), 128'(rv), 128'(VECS[i].d));
            end else begin
                do_write(VECS[i].a, VECS[i].d);
            end
        end

        // R9: pin mapping and flat bus layout
        check("R9 phy_pwr_on", 128'(phy_pwr_on), 128'(1));
        check("R9 dll_en", 128'(dll_en), 128'(1));
        check("R9 word0 on ctrl_bits", 128'(ctrl_bits[15:0]), 128'(16'hA505));
        check("R9 word5 on ctrl_bits", 128'(ctrl_bits[95:80]), 128'(16'hBEEF));

        // R2 R9: clear power bit only, delay line stays on
        do_write(8'h18, 32'h0001_0000);
        check("R2 pwr cleared", 128'(phy_pwr_on), 128'(0));
        check("R2 dll kept", 128'(dll_en), 128'(1));

        // R6: unmapped writes leave every control bit intact
        snap = ctrl_bits;
        do_write(8'h20, 32'hFFFF_FFFF);
        do_write(8'h1C, 32'hFFFF_0000);
        do_write(8'h3C, 32'hFFFF_FFFF);
        do_write(8'h05, 32'hFFFF_FFFF);
        do_write(8'h1A, 32'hFFFF_FFFF);
        check("R6 ctrl_bits unchanged", 128'(ctrl_bits), 128'(snap));

        // R5: status word for each input pattern
        cal_done = 1'b1; dll_ready = 1'b0;
        do_read(8'h20, rv);
        check("R5 cal_done only", 128'(rv), 128'(32'h40));
        dll_ready = 1'b1;
        do_read(8'h20, rv);
        check("R5 both set", 128'(rv), 128'(32'h60));
        cal_done = 1'b0;
        do_read(8'h20, rv);
        check("R5 dll_ready only", 128'(rv), 128'(32'h20));
        dll_ready = 1'b0;
        do_read(8'h20, rv);
        check("R5 none set", 128'(rv), 128'(32'h0));

        // R8: same-cycle read and write returns the old value
        @(negedge clk);
        addr = 8'h08; wdata = 32'hFFFF_7777; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8 read before write", 128'(rdata), 128'(0));
        do_read(8'h08, rv);
        check("R8 write landed", 128'(rv), 128'(32'h7777));
        // R8: hold across idle cycles and writes
        addr = 8'h00;
        do_write(8'h08, 32'hFFFF_0000);
        repeat (3) @(negedge clk);
        check("R8 rdata held", 128'(rdata), 128'(32'h7777));

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 ctrl_bits mid-run reset", 128'(ctrl_bits), 128'(0));
        check("R1 rdata mid-run reset", 128'(rdata), 128'(0));
        check("R1 pwr mid-run reset", 128'(phy_pwr_on), 128'(0));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule